// File: doc/BRIEF.md
# Cross-Flow MAC Learning Table

This block is the forwarding core of a learning switch. It keeps a small table of address-to-port state and serves one frame per cycle. For each frame it reads the table with one header field to pick an egress port, and it writes the ingress port into the table under another header field. In the usual setup the destination MAC is the read key and the source MAC is the write key. One table therefore both learns where stations live and forwards traffic towards them.

Two configuration inputs select the read key and the write key independently, and either key can come from either address field. A read hit gives a single egress port. A read miss, or an all-ones (broadcast) read key, gives a flood to every port except the one the frame arrived on. The result is registered and appears one cycle after the frame. New sources take the lowest free slot. Once the table is full, new sources replace entries in round-robin order.

Top module: `xflow_learn_table`

## Requirements
- R1: After reset, `res_valid`, `res_flood`, `res_port` and `res_port_mask` are all zero, and the table holds no entries.
- R2: A frame presented with `frm_valid` high yields `res_valid` high in the next cycle. When its read key matches a stored entry, the result shows `res_flood`=0, `res_port` equal to the stored port, and `res_port_mask` with only bit `res_port` set (bit p stands for port p).
- R3: On a read miss, the result shows `res_flood`=1, `res_port`=0, and `res_port_mask` with every port bit set except the bit of the frame's ingress port.
- R4: Each valid frame stores its ingress port under its write key. If the write key is already present, only that entry's port is overwritten and no other slot is used.
- R5: A write key that is not yet present takes the lowest-numbered free slot.
- R6: When all slots are in use, a new write key replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each replacement only.
- R7: A lookup sees the table as it stood before the same frame's update. A frame whose read and write keys are equal therefore sees the old port, or a miss.
- R8: A read key of all ones always floods, even if an all-ones key has been learned. Such a frame still performs its update.
- R9: `cfg_rd_key_sel` and `cfg_wr_key_sel` each pick a field: 0 selects the destination MAC and 1 selects the source MAC. Each applies to the frame presented in the same cycle.
- R10: In a cycle with `frm_valid` low, the table does not change, `res_valid` is low in the next cycle, and the other result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A frame is presented this cycle |
| frm_dst_mac | input | 48 | Destination MAC address of the frame |
| frm_src_mac | input | 48 | Source MAC address of the frame |
| frm_in_port | input | PORT_W | Ingress port of the frame |
| cfg_rd_key_sel | input | 1 | Read key field: 0 destination, 1 source |
| cfg_wr_key_sel | input | 1 | Write key field: 0 destination, 1 source |
| res_valid | output | 1 | Result for the previous cycle's frame |
| res_flood | output | 1 | Result is a flood |
| res_port | output | PORT_W | Egress port on a hit, zero on a flood |
| res_port_mask | output | NUM_PORTS | Egress port set, one bit per port |

## Verification
The bench builds the block with four slots and four ports. With so few slots, a sweep over seven addresses, one of them all ones, fills the table and forces several round-robin replacements. The sweep crosses every destination with every source, including equal pairs and broadcasts, and is repeated under three key-selection settings. Because the ingress port cycles through all four values, every flood mask shape and every stored port value is reached.

// File: rtl/xflow_pkg.sv
package xflow_pkg;
  localparam int unsigned MAC_W = 48;

  typedef enum logic {
    KEY_FROM_DST = 1'b0,
    KEY_FROM_SRC = 1'b1
  } key_sel_e;
endpackage

// File: rtl/xflow_key_mux.sv
module xflow_key_mux
  import xflow_pkg::*;
#(
  parameter int unsigned KEY_W = MAC_W
) (
  input  logic [KEY_W-1:0] dst_field,
  input  logic [KEY_W-1:0] src_field,
  input  key_sel_e         sel,
  output logic [KEY_W-1:0] key,
  output logic             key_all_ones
);
  always_comb begin
    unique case (sel)
      KEY_FROM_SRC: key = src_field;
      default:      key = dst_field;
    endcase
    key_all_ones = &key;
  end
endmodule

// File: rtl/xflow_state_table.sv
module xflow_state_table #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned KEY_W = 48,
  parameter int unsigned VAL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] rd_key,
  output logic             rd_hit,
  output logic [VAL_W-1:0] rd_val,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [KEY_W-1:0] key_q [DEPTH];
  logic [VAL_W-1:0] val_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [IDX_W-1:0] rr_q, rr_d;

  logic [DEPTH-1:0] rd_match, wr_match, slot_we;
  logic [IDX_W-1:0] match_idx, free_idx, tgt_idx;
  logic             free_any, replace;

  // per-slot comparators
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign rd_match[g] = vld_q[g] && (key_q[g] == rd_key);
    assign wr_match[g] = vld_q[g] && (key_q[g] == wr_key);
  end

  // read side: or-merge of the (at most one) matching value
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_match[i]) rd_val = rd_val | val_q[i];
    end
    rd_hit = |rd_match;
  end

  // write side: slot choice and next state
  always_comb begin
    match_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_match[i]) match_idx = IDX_W'(i);
    end
    free_idx = '0;
    free_any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
    replace = wr_en && !(|wr_match) && !free_any;
    if (|wr_match)     tgt_idx = match_idx;
    else if (free_any) tgt_idx = free_idx;
    else               tgt_idx = rr_q;
    slot_we = wr_en ? (DEPTH'(1) << tgt_idx) : '0;
    vld_d   = vld_q | slot_we;
    if (replace) rr_d = (rr_q == LAST_IDX) ? '0 : rr_q + IDX_W'(1);
    else         rr_d = rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) begin
        key_q[i] <= wr_key;
        val_q[i] <= wr_val;
      end
    end
  end

  AST_UNIQUE_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_match)); // R4

  AST_IDLE_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q)); // R10

  AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_q != $past(rr_q)) |-> (&$past(vld_q))); // R6
endmodule

// File: rtl/xflow_result.sv
module xflow_result #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 bcast,
  input  logic                 hit,
  input  logic [PORT_W-1:0]    hit_port,
  input  logic [PORT_W-1:0]    in_port,
  output logic                 res_valid,
  output logic                 res_flood,
  output logic [PORT_W-1:0]    res_port,
  output logic [NUM_PORTS-1:0] res_mask
);
  logic                 flood_d;
  logic [PORT_W-1:0]    port_d;
  logic [NUM_PORTS-1:0] mask_d;

  always_comb begin
    flood_d = bcast || !hit;
    port_d  = flood_d ? '0 : hit_port;
    for (int p = 0; p < NUM_PORTS; p++) begin
      mask_d[p] = flood_d ? (PORT_W'(p) != in_port) : (PORT_W'(p) == hit_port);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_flood <= 1'b0;
      res_port  <= '0;
      res_mask  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_flood <= flood_d;
        res_port  <= port_d;
        res_mask  <= mask_d;
      end
    end
  end

  AST_HIT_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_flood) |-> $onehot(res_mask)); // R2
endmodule

// File: rtl/xflow_learn_table.sv
module xflow_learn_table
  import xflow_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_valid,
  input  logic [47:0]          frm_dst_mac,
  input  logic [47:0]          frm_src_mac,
  input  logic [PORT_W-1:0]    frm_in_port,
  input  logic                 cfg_rd_key_sel,
  input  logic                 cfg_wr_key_sel,
  output logic                 res_valid,
  output logic                 res_flood,
  output logic [PORT_W-1:0]    res_port,
  output logic [NUM_PORTS-1:0] res_port_mask
);
  logic [MAC_W-1:0]  rd_key, wr_key;
  logic              rd_bcast, wr_bcast_unused;
  logic              tbl_hit;
  logic [PORT_W-1:0] tbl_port;

  xflow_key_mux #(.KEY_W(MAC_W)) i_rd_key (
    .dst_field    (frm_dst_mac),
    .src_field    (frm_src_mac),
    .sel          (key_sel_e'(cfg_rd_key_sel)),
    .key          (rd_key),
    .key_all_ones (rd_bcast)
  );

  xflow_key_mux #(.KEY_W(MAC_W)) i_wr_key (
    .dst_field    (frm_dst_mac),
    .src_field    (frm_src_mac),
    .sel          (key_sel_e'(cfg_wr_key_sel)),
    .key          (wr_key),
    .key_all_ones (wr_bcast_unused)
  );

  xflow_state_table #(.DEPTH(DEPTH), .KEY_W(MAC_W), .VAL_W(PORT_W)) i_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_key (rd_key),
    .rd_hit (tbl_hit),
    .rd_val (tbl_port),
    .wr_en  (frm_valid),
    .wr_key (wr_key),
    .wr_val (frm_in_port)
  );

  xflow_result #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (frm_valid),
    .bcast     (rd_bcast),
    .hit       (tbl_hit),
    .hit_port  (tbl_port),
    .in_port   (frm_in_port),
    .res_valid (res_valid),
    .res_flood (res_flood),
    .res_port  (res_port),
    .res_mask  (res_port_mask)
  );

  AST_BCAST_FLOODS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (&rd_key)) |=> res_flood); // R8

  AST_FLOOD_SKIPS_INGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (!res_flood || !res_port_mask[$past(frm_in_port)])); // R3

  AST_RESULT_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid); // R2

  AST_NO_RESULT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid); // R10
endmodule

// File: tb/test_xflow_learn_table.sv
module test_xflow_learn_table;
  localparam int DEPTH = 4;
  localparam int NP    = 4;
  localparam int PW    = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frm_valid;
  logic [47:0]   frm_dst_mac, frm_src_mac;
  logic [PW-1:0] frm_in_port;
  logic          cfg_rd_key_sel, cfg_wr_key_sel;
  logic          res_valid, res_flood;
  logic [PW-1:0] res_port;
  logic [NP-1:0] res_port_mask;

  int n_chk  = 0;
  int n_fail = 0;

  // requirement model of the table
  logic [47:0]   m_key [DEPTH];
  logic [PW-1:0] m_port[DEPTH];
  bit            m_vld [DEPTH];
  int            m_rr;

  always #10 clk = ~clk;

  xflow_learn_table #(.DEPTH(DEPTH), .NUM_PORTS(NP), .PORT_W(PW)) i_xflow_learn_table (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
    .frm_dst_mac(frm_dst_mac), .frm_src_mac(frm_src_mac), .frm_in_port(frm_in_port),
    .cfg_rd_key_sel(cfg_rd_key_sel), .cfg_wr_key_sel(cfg_wr_key_sel),
    .res_valid(res_valid), .res_flood(res_flood), .res_port(res_port),
    .res_port_mask(res_port_mask)
  );

  function automatic logic [47:0] mac(int k);
    if (k == 6) return 48'hFFFF_FFFF_FFFF;
    return {40'h02_1C_00_00_00, 8'(k)};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    m_rr = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; frm_valid = 1'b0; frm_dst_mac = '0; frm_src_mac = '0;
    frm_in_port = '0; cfg_rd_key_sel = 1'b0; cfg_wr_key_sel = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one frame, then check its result at the following negedge
  task automatic frame(int d, int s, int p, bit rsel, bit wsel, string tag_in);
    logic [47:0]   rk, wk;
    bit            hit, flood;
    logic [PW-1:0] hp;
    logic [NP-1:0] emask;
    int            slot;
    string         tag;
    rk = rsel ? mac(s) : mac(d);
    wk = wsel ? mac(s) : mac(d);
    hit = 0; hp = '0;
    for (int i = 0; i < DEPTH; i++)
      if (m_vld[i] && m_key[i] == rk) begin hit = 1; hp = m_port[i]; end
    flood = (&rk) || !hit;
    emask = flood ? (NP'({NP{1'b1}}) & ~(NP'(1) << p)) : (NP'(1) << hp);
    if (tag_in != "")   tag = tag_in;
    else if (&rk)       tag = "R8";
    else if (rk == wk)  tag = "R7";
    else if (rsel || !wsel) tag = "R9";
    else                tag = hit ? "R2" : "R3";
    // model update
    slot = -1;
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_key[i] == wk) slot = i;
    if (slot < 0) for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
    if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % DEPTH; end
    frm_valid = 1'b1; frm_dst_mac = mac(d); frm_src_mac = mac(s);
    frm_in_port = PW'(p); cfg_rd_key_sel = rsel; cfg_wr_key_sel = wsel;
    @(negedge clk);
    m_vld[slot] = 1; m_key[slot] = wk; m_port[slot] = PW'(p);
    frm_valid = 1'b0;
    chk(res_valid == 1'b1, tag, 64'(res_valid), 64'd1);
    chk(res_flood == flood, tag, 64'(res_flood), 64'(flood));
    chk(res_port == (flood ? PW'(0) : hp), tag, 64'(res_port), 64'(flood ? PW'(0) : hp));
    chk(res_port_mask == emask, tag, 64'(res_port_mask), 64'(emask));
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk(res_valid == 0 && res_flood == 0 && res_port == 0 && res_port_mask == 0,
        "R1", {res_valid, res_flood, 4'(res_port), 4'(res_port_mask)}, 0);
    frame(0, 1, 2, 0, 1, "R1");            // empty table -> miss
    // R10: idle cycle gives no result and holds the others
    @(negedge clk);
    chk(res_valid == 0, "R10", 64'(res_valid), 0);
    chk(res_port_mask == 4'b1011, "R10", 64'(res_port_mask), 64'hB);
    frame(1, 0, 3, 0, 1, "R10");           // src 0 still unknown, dst 1 learned earlier
    // R4: overwrite moves a station without using a slot
    frame(2, 1, 0, 0, 1, "R4");
    frame(1, 2, 1, 0, 1, "R4");
    // R5 / R6: fill from lowest free slot, then round-robin replacement
    do_reset();
    for (int k = 0; k < 4; k++) frame(6, k, k, 0, 1, "R5");
    frame(6, 4, 1, 0, 1, "R6");            // replaces slot 0 (mac 0)
    frame(0, 4, 1, 0, 1, "R6");            // mac 0 gone -> flood
    frame(1, 4, 2, 0, 1, "R6");            // mac 1 still at port 1
    frame(6, 5, 3, 0, 1, "R6");            // replaces slot 1 (mac 1)
    frame(1, 5, 0, 0, 1, "R6");            // mac 1 gone
    frame(2, 5, 0, 0, 1, "R5");            // mac 2 still at port 2
    // sweeps under three key selections
    do_reset();
    for (int d = 0; d < 7; d++)
      for (int s = 0; s < 7; s++) frame(d, s, (d + s) % NP, 0, 1, "");
    for (int d = 0; d < 7; d++)
      for (int s = 0; s < 7; s++) frame(d, s, (d + 3 * s) % NP, 1, 0, "");
    for (int d = 0; d < 7; d++)
      for (int s = 0; s < 7; s++) frame(d, s, (2 * d + s) % NP, 0, 0, "");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule